// File: doc/BRIEF.md
# Watchdog Register Front End with Magic Unlock

This block is the software-facing register file for a two-stage watchdog countdown timer. It decodes a simple memory-mapped bus carrying an address, write data, an access size (byte, halfword or word), a write strobe and a read strobe. It holds the watchdog's configuration and lock/enable registers and drives their contents to the countdown timer as level outputs. The timer itself lives outside this block.

Two preload values and a keepalive / flag-clear command are protected. A write to any of them takes effect only straight after a two-write magic sequence on the command offset. The next halfword or word write uses up that permission, whatever it targets. A lock bit freezes the enable and mode fields until the next reset. The timer's previous-reboot flag can be read back through the command offset.

Top module: `wdr_regfile`

## Requirements
- R1: After synchronous reset: both preloads are 0xFFFFF, reboot is enabled, slow prescale is selected, interrupt type is 0, enable, free-run and lock are 0, and the pulse outputs and read data are 0.
- R2: A halfword or word write of 0x80 to offset 0x0C selects step one. A write of 0x86 to offset 0x0C while in step one arms the sequencer. The next halfword or word write to any offset other than 0x10 or 0x14 is granted and disarms it. A write of 0x80 always returns to step one.
- R3: A granted word write to offset 0x00 loads the stage-1 preload, and one to offset 0x04 loads the stage-2 preload. Each takes data bits 19:0, and the output shows the new value one cycle after the write.
- R4: A granted halfword write to offset 0x0C pulses restart for one cycle if bit 8 is set. It pulses flag-clear for one cycle if bit 9 or bit 12 is set.
- R5: Protected writes made while the sequencer is not armed change nothing. A granted write whose size or offset matches no protected register only disarms.
- R6: A halfword or word write other than the magic values while in step one returns the sequencer to idle, so a following 0x86 does not arm it.
- R7: Byte writes only advance the sequence using their low 8 bits. A non-magic byte write neither applies an update nor changes the sequencer state.
- R8: Writes to offsets 0x10 and 0x14 never change the sequencer state.
- R9: The read data is registered and is valid the cycle after the read strobe. A halfword read of 0x0C returns the previous-reboot flag in bits 9 and 12. A read of 0x10 returns the configuration in bits 5, 2 and 1:0. A read of 0x14 returns free-run, enable and lock in bits 2, 1 and 0. Any other read returns 0.
- R10: A write to offset 0x10 (any defined size: 0 byte, 1 halfword, 2 word) sets the following: bit 5 set disables reboot, bit 2 set selects the fast prescale, and bits 1:0 give the interrupt type. Size code 3 is reserved and ignored everywhere.
- R11: A write to offset 0x14 while unlocked sets lock from bit 0, enable from bit 1 and free-run from bit 2. Once lock is 1, writes to 0x14 are ignored until reset.
- R12: A write to 0x14 that turns enable from 0 to 1 pulses restart in the same cycle that enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, low lanes used for narrow sizes |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| prev_reboot_i | input | 1 | Previous-reboot flag from the timer |
| pre1_o | output | 20 | Stage-1 preload |
| pre2_o | output | 20 | Stage-2 preload |
| wd_enable_o | output | 1 | Timer enable |
| wd_free_run_o | output | 1 | Restart stage 1 after stage-2 expiry |
| wd_locked_o | output | 1 | Lock state |
| reboot_en_o | output | 1 | Reboot on stage-2 expiry |
| fast_scale_o | output | 1 | Fast prescale select |
| irq_type_o | output | 2 | Stage-1 interrupt type |
| restart_o | output | 1 | One-cycle restart of stage 1 |
| clr_flag_o | output | 1 | One-cycle clear of the previous-reboot flag |

## Verification
Every register output and both pulses come one clock edge after the write strobe. The bench therefore drives each access at a falling edge and samples everything at the next falling edge, which is the single cycle in which a pulse is high. Read data is due one edge after the read strobe and is sampled the same way. The random section replays each access through a bench model whose arm state advances per access, so a consumed or dropped unlock shows up at the protected write that follows.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    parameter int ADDR_W    = 5;
    parameter int BUS_W     = 32;
    parameter int PRELOAD_W = 20;

    localparam int OFS_PRE1 = 'h00;
    localparam int OFS_PRE2 = 'h04;
    localparam int OFS_KICK = 'h0C;
    localparam int OFS_CFG  = 'h10;
    localparam int OFS_LOCK = 'h14;

    localparam logic [7:0] MAGIC_ONE = 8'h80;
    localparam logic [7:0] MAGIC_TWO = 8'h86;

    localparam int BIT_KEEPALIVE = 8;
    localparam int BIT_CLR_A     = 9;
    localparam int BIT_CLR_B     = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } bus_size_e;

    typedef enum logic [1:0] {
        ULK_IDLE = 2'd0,
        ULK_STEP = 2'd1,
        ULK_OPEN = 2'd2
    } ulk_state_e;

    typedef struct packed {
        logic       no_reboot;
        logic       fast;
        logic [1:0] irq_type;
    } cfg_t;

    typedef struct packed {
        logic free_run;
        logic enable;
        logic lock;
    } lck_t;

    localparam cfg_t CFG_RESET = '{no_reboot: 1'b0, fast: 1'b0, irq_type: 2'd0};
    localparam lck_t LCK_RESET = '{free_run: 1'b0, enable: 1'b0, lock: 1'b0};

    function automatic logic [BUS_W-1:0] lane_value(input logic [BUS_W-1:0] d,
                                                    input bus_size_e s);
        case (s)
            SZ_BYTE: return BUS_W'(d[7:0]);
            SZ_HALF: return BUS_W'(d[15:0]);
            SZ_WORD: return d;
            default: return '0;
        endcase
    endfunction

    function automatic logic multi_lane(input bus_size_e s);
        return (s == SZ_HALF) || (s == SZ_WORD);
    endfunction

    function automatic int stage_offset(input int idx);
        return (idx == 0) ? OFS_PRE1 : OFS_PRE2;
    endfunction

endpackage

// File: rtl/wdr_unlock_seq.sv
module wdr_unlock_seq
    import wdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  bus_size_e         size,
    output logic              grant,
    output ulk_state_e        state
);

    logic [BUS_W-1:0] lane;
    logic             at_kick;
    logic             guarded;
    logic             hit_one;
    logic             hit_two;
    logic             consumes;
    ulk_state_e       state_d;

    assign lane    = lane_value(wdata, size);
    assign at_kick = (addr == ADDR_W'(OFS_KICK));
    assign guarded = (addr != ADDR_W'(OFS_CFG)) && (addr != ADDR_W'(OFS_LOCK));
    assign hit_one = wr && at_kick && (size != SZ_RSVD) && (lane == BUS_W'(MAGIC_ONE));
    assign hit_two = wr && at_kick && (size != SZ_RSVD) && (lane == BUS_W'(MAGIC_TWO));

    // Any halfword or word write outside the control offsets leaves a non-idle state.
    assign consumes = wr && multi_lane(size) && guarded;

    always_comb begin
        state_d = state;
        if (hit_one) begin
            state_d = ULK_STEP;
        end else if (hit_two && state == ULK_STEP) begin
            state_d = ULK_OPEN;
        end else if (consumes) begin
            state_d = ULK_IDLE;
        end
    end

    assign grant = consumes && !hit_one && (state == ULK_OPEN);

    always_ff @(posedge clk) begin
        if (rst) state <= ULK_IDLE;
        else     state <= state_d;
    end

endmodule

// File: rtl/wdr_ctrl_regs.sv
module wdr_ctrl_regs
    import wdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [5:0]        wdata_lo,
    input  bus_size_e         size,
    output cfg_t              cfg,
    output lck_t              lck,
    output logic              en_rise
);

    logic cfg_we;
    logic lck_we;

    assign cfg_we  = wr && (size != SZ_RSVD) && (addr == ADDR_W'(OFS_CFG));
    assign lck_we  = wr && (size != SZ_RSVD) && (addr == ADDR_W'(OFS_LOCK)) && !lck.lock;
    assign en_rise = lck_we && wdata_lo[1] && !lck.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
            lck <= LCK_RESET;
        end else begin
            if (cfg_we) begin
                cfg.no_reboot <= wdata_lo[5];
                cfg.fast      <= wdata_lo[2];
                cfg.irq_type  <= wdata_lo[1:0];
            end
            if (lck_we) begin
                lck.lock     <= wdata_lo[0];
                lck.enable   <= wdata_lo[1];
                lck.free_run <= wdata_lo[2];
            end
        end
    end

endmodule

// File: rtl/wdr_prot_regs.sv
module wdr_prot_regs
    import wdr_pkg::*;
#(
    parameter int PW = PRELOAD_W   // must be at least 13 so the command bits fit
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PW-1:0]     wdata,
    input  bus_size_e         size,
    input  logic              en_rise,
    output logic [PW-1:0]     pre [2],
    output logic              restart,
    output logic              clr_flag
);

    localparam logic [PW-1:0] PRE_RESET = '1;

    logic kick_cmd;

    for (genvar g = 0; g < 2; g++) begin : g_pre
        logic ld;
        assign ld = grant && (size == SZ_WORD) && (addr == ADDR_W'(stage_offset(g)));
        always_ff @(posedge clk) begin
            if (rst)     pre[g] <= PRE_RESET;
            else if (ld) pre[g] <= wdata;
        end
    end

    assign kick_cmd = grant && (size == SZ_HALF) && (addr == ADDR_W'(OFS_KICK));

    always_ff @(posedge clk) begin
        if (rst) begin
            restart  <= 1'b0;
            clr_flag <= 1'b0;
        end else begin
            restart  <= (kick_cmd && wdata[BIT_KEEPALIVE]) || en_rise;
            clr_flag <= kick_cmd && (wdata[BIT_CLR_A] || wdata[BIT_CLR_B]);
        end
    end

endmodule

// File: rtl/wdr_readback.sv
module wdr_readback
    import wdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  bus_size_e         size,
    input  logic              flag,
    input  cfg_t              cfg,
    input  lck_t              lck,
    output logic [BUS_W-1:0]  rdata
);

    logic [BUS_W-1:0] view;

    always_comb begin
        view = '0;
        if (addr == ADDR_W'(OFS_KICK) && size == SZ_HALF) begin
            view[BIT_CLR_A] = flag;
            view[BIT_CLR_B] = flag;
        end else if (addr == ADDR_W'(OFS_CFG) && size != SZ_RSVD) begin
            view[5]   = cfg.no_reboot;
            view[2]   = cfg.fast;
            view[1:0] = cfg.irq_type;
        end else if (addr == ADDR_W'(OFS_LOCK) && size != SZ_RSVD) begin
            view[2:0] = {lck.free_run, lck.enable, lck.lock};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= view;
        else         rdata <= '0;
    end

endmodule

// File: rtl/wdr_regfile.sv
module wdr_regfile
    import wdr_pkg::*;
#(
    parameter int PW = PRELOAD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              prev_reboot_i,
    output logic [PW-1:0]     pre1_o,
    output logic [PW-1:0]     pre2_o,
    output logic              wd_enable_o,
    output logic              wd_free_run_o,
    output logic              wd_locked_o,
    output logic              reboot_en_o,
    output logic              fast_scale_o,
    output logic [1:0]        irq_type_o,
    output logic              restart_o,
    output logic              clr_flag_o
);

    bus_size_e  sz;
    ulk_state_e ulk_st;
    logic       grant;
    logic       en_rise;
    cfg_t       cfg;
    lck_t       lck;
    logic [PW-1:0] pre [2];

    assign sz = bus_size_e'(bus_size);

    wdr_unlock_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .size  (sz),
        .grant (grant),
        .state (ulk_st)
    );

    wdr_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata_lo (bus_wdata[5:0]),
        .size     (sz),
        .cfg      (cfg),
        .lck      (lck),
        .en_rise  (en_rise)
    );

    wdr_prot_regs #(.PW(PW)) u_prot (
        .clk      (clk),
        .rst      (rst),
        .grant    (grant),
        .addr     (bus_addr),
        .wdata    (bus_wdata[PW-1:0]),
        .size     (sz),
        .en_rise  (en_rise),
        .pre      (pre),
        .restart  (restart_o),
        .clr_flag (clr_flag_o)
    );

    wdr_readback u_rb (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .size  (sz),
        .flag  (prev_reboot_i),
        .cfg   (cfg),
        .lck   (lck),
        .rdata (bus_rdata)
    );

    assign pre1_o        = pre[0];
    assign pre2_o        = pre[1];
    assign wd_enable_o   = lck.enable;
    assign wd_free_run_o = lck.free_run;
    assign wd_locked_o   = lck.lock;
    assign reboot_en_o   = !cfg.no_reboot;
    assign fast_scale_o  = cfg.fast;
    assign irq_type_o    = cfg.irq_type;

endmodule

// File: rtl/wdr_regfile_chk.sv
module wdr_regfile_chk
    import wdr_pkg::*;
#(
    parameter int PW = PRELOAD_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [PW-1:0]     pre1_o,
    input logic              wd_enable_o,
    input logic              wd_free_run_o,
    input logic              wd_locked_o,
    input logic              reboot_en_o,
    input logic              fast_scale_o,
    input logic [1:0]        irq_type_o,
    input logic              restart_o,
    input logic [1:0]        ulk_st
);

    // R2
    arm_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ulk_st == ULK_OPEN) |-> ($past(ulk_st) == ULK_STEP || $past(ulk_st) == ULK_OPEN));

    // R3
    pre1_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pre1_o) |-> $past(bus_wr && bus_size == 2'd2 && bus_addr == ADDR_W'(OFS_PRE1)
                                   && ulk_st == ULK_OPEN));

    // R4
    restart_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> $past(bus_wr));

    // R9
    rdata_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata != '0) |-> $past(bus_rd));

    // R10
    cfg_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({reboot_en_o, fast_scale_o, irq_type_o})
            |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_CFG)));

    // R11
    lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        wd_locked_o |=> (wd_locked_o && $stable(wd_enable_o) && $stable(wd_free_run_o)));

    // R12
    enable_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_enable_o) |-> restart_o);

endmodule

bind wdr_regfile wdr_regfile_chk #(.PW(PW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .pre1_o        (pre1_o),
    .wd_enable_o   (wd_enable_o),
    .wd_free_run_o (wd_free_run_o),
    .wd_locked_o   (wd_locked_o),
    .reboot_en_o   (reboot_en_o),
    .fast_scale_o  (fast_scale_o),
    .irq_type_o    (irq_type_o),
    .restart_o     (restart_o),
    .ulk_st        (ulk_st)
);

// File: tb/sim_wdr_regfile.sv
`timescale 1ns/1ps
module sim_wdr_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        prev_reboot;
    logic [19:0] pre1_o, pre2_o;
    logic        wd_enable_o, wd_free_run_o, wd_locked_o, reboot_en_o, fast_scale_o;
    logic [1:0]  irq_type_o;
    logic        restart_o, clr_flag_o;
    logic        set_flag_req = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    int          m_st;
    logic [19:0] m_pre1, m_pre2;
    logic        m_en, m_free, m_lock, m_noreb, m_fast, m_flag;
    logic [1:0]  m_irq;

    always #5 clk = ~clk;

    // stub of the countdown timer's previous-reboot flag
    always_ff @(posedge clk) begin
        if (rst)               prev_reboot <= 1'b0;
        else if (set_flag_req) prev_reboot <= 1'b1;
        else if (clr_flag_o)   prev_reboot <= 1'b0;
    end

    wdr_regfile u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .prev_reboot_i(prev_reboot), .pre1_o(pre1_o), .pre2_o(pre2_o),
        .wd_enable_o(wd_enable_o), .wd_free_run_o(wd_free_run_o),
        .wd_locked_o(wd_locked_o), .reboot_en_o(reboot_en_o),
        .fast_scale_o(fast_scale_o), .irq_type_o(irq_type_o),
        .restart_o(restart_o), .clr_flag_o(clr_flag_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_pre1 = 20'hFFFFF; m_pre2 = 20'hFFFFF;
        m_en = 0; m_free = 0; m_lock = 0; m_noreb = 0; m_fast = 0; m_irq = 0; m_flag = 0;
    endtask

    task automatic check_levels(input string req);
        check(req, "pre1", 32'(pre1_o), 32'(m_pre1));
        check(req, "pre2", 32'(pre2_o), 32'(m_pre2));
        check(req, "lockreg", {29'd0, wd_free_run_o, wd_enable_o, wd_locked_o},
              {29'd0, m_free, m_en, m_lock});
        check(req, "cfg", {28'd0, reboot_en_o, fast_scale_o, irq_type_o},
              {28'd0, !m_noreb, m_fast, m_irq});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic wr_op(input logic [4:0] a, input logic [31:0] d,
                         input logic [1:0] s, input string req);
        logic [31:0] lane;
        logic kick, m1, m2, multi, guarded, e_rs, e_clr;
        lane = (s == 2'd0) ? {24'd0, d[7:0]} : (s == 2'd1) ? {16'd0, d[15:0]} :
               (s == 2'd2) ? d : 32'd0;
        kick    = (a == 5'h0C) && (s != 2'd3);
        m1      = kick && lane == 32'h80;
        m2      = kick && lane == 32'h86;
        multi   = (s == 2'd1) || (s == 2'd2);
        guarded = (a != 5'h10) && (a != 5'h14);
        e_rs = 0; e_clr = 0;
        if (m1) m_st = 1;
        else if (m2 && m_st == 1) m_st = 2;
        else if (multi && guarded) begin
            if (m_st == 2) begin
                if (s == 2'd2 && a == 5'h00) m_pre1 = d[19:0];
                if (s == 2'd2 && a == 5'h04) m_pre2 = d[19:0];
                if (s == 2'd1 && a == 5'h0C) begin
                    e_rs  = d[8];
                    e_clr = d[9] | d[12];
                end
            end
            m_st = 0;
        end
        if (a == 5'h10 && s != 2'd3) begin
            m_noreb = d[5]; m_fast = d[2]; m_irq = d[1:0];
        end
        if (a == 5'h14 && s != 2'd3 && !m_lock) begin
            if (d[1] && !m_en) e_rs = 1;
            m_lock = d[0]; m_en = d[1]; m_free = d[2];
        end
        if (e_clr) m_flag = 0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = s; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(req, "restart", 32'(restart_o), 32'(e_rs));
        check(req, "clr_flag", 32'(clr_flag_o), 32'(e_clr));
        check_levels(req);
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a, input logic [1:0] s);
        if (a == 5'h0C && s == 2'd1) return {19'd0, m_flag, 2'd0, m_flag, 9'd0};
        if (a == 5'h10 && s != 2'd3) return {26'd0, m_noreb, 2'd0, m_fast, m_irq};
        if (a == 5'h14 && s != 2'd3) return {29'd0, m_free, m_en, m_lock};
        return 32'd0;
    endfunction

    task automatic rd_op(input logic [4:0] a, input logic [1:0] s, input string req);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, "rdata", bus_rdata, exp_read(a, s));
    endtask

    task automatic set_flag();
        @(negedge clk);
        set_flag_req = 1'b1;
        @(negedge clk);
        set_flag_req = 1'b0;
        m_flag = 1;
    endtask

    task automatic unlock(input logic [1:0] s);
        wr_op(5'h0C, 32'h80, s, "R2");
        wr_op(5'h0C, 32'h86, s, "R2");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        model_reset();
        do_reset();
        // R1 reset state
        check("R1", "restart", 32'(restart_o), 0);
        check("R1", "clr_flag", 32'(clr_flag_o), 0);
        check("R1", "rdata", bus_rdata, 0);
        check_levels("R1");
        rd_op(5'h10, 2'd1, "R9");
        rd_op(5'h14, 2'd0, "R9");

        // R5 no unlock: ignored
        wr_op(5'h00, 32'h1, 2'd2, "R5");
        // R2 R3 unlock then load stage 1
        unlock(2'd1);
        wr_op(5'h00, 32'h12345678, 2'd2, "R3");
        // R5 the arm was consumed
        wr_op(5'h04, 32'h2, 2'd2, "R5");
        unlock(2'd2);
        wr_op(5'h04, 32'hFFFABCDE, 2'd2, "R3");
        // R5 size mismatch only disarms
        unlock(2'd1);
        wr_op(5'h00, 32'h5, 2'd1, "R5");
        wr_op(5'h00, 32'h6, 2'd2, "R5");
        // R6 non-magic in step one
        wr_op(5'h0C, 32'h80, 2'd1, "R6");
        wr_op(5'h0C, 32'h55, 2'd1, "R6");
        wr_op(5'h0C, 32'h86, 2'd1, "R6");
        wr_op(5'h00, 32'h9, 2'd2, "R6");
        // R7 byte writes advance only
        wr_op(5'h0C, 32'h80, 2'd0, "R7");
        wr_op(5'h0C, 32'h86, 2'd0, "R7");
        wr_op(5'h00, 32'h1, 2'd0, "R7");
        wr_op(5'h00, 32'h7, 2'd2, "R7");
        // R8 control writes leave the arm in place
        unlock(2'd1);
        wr_op(5'h10, 32'h0, 2'd2, "R8");
        wr_op(5'h00, 32'h33, 2'd2, "R8");
        // R4 keepalive and flag clear, R9 flag readback
        unlock(2'd1);
        wr_op(5'h0C, 32'h100, 2'd1, "R4");
        set_flag();
        rd_op(5'h0C, 2'd1, "R9");
        rd_op(5'h0C, 2'd2, "R9");
        rd_op(5'h08, 2'd1, "R9");
        unlock(2'd1);
        wr_op(5'h0C, 32'h1000, 2'd1, "R4");
        rd_op(5'h0C, 2'd1, "R9");
        set_flag();
        unlock(2'd2);
        wr_op(5'h0C, 32'h300, 2'd1, "R4");
        rd_op(5'h0C, 2'd1, "R4");
        // R10 configuration
        wr_op(5'h10, 32'h27, 2'd1, "R10");
        rd_op(5'h10, 2'd1, "R10");
        wr_op(5'h10, 32'h01, 2'd3, "R10");
        // R12 enable rise, R11 lock
        wr_op(5'h14, 32'h2, 2'd0, "R12");
        wr_op(5'h14, 32'h6, 2'd0, "R12");
        wr_op(5'h14, 32'h7, 2'd0, "R11");
        wr_op(5'h14, 32'h0, 2'd2, "R11");
        rd_op(5'h14, 2'd0, "R11");
        do_reset();
        check_levels("R1");

        // random mix
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 1500; i++) begin
            logic [4:0]  a;
            logic [31:0] d;
            logic [1:0]  s;
            int pick;
            pick = int'($urandom_range(0, 5));
            a = (pick == 5) ? 5'h08 : 5'(pick * 4);
            if (pick == 1 || pick == 2) a = (pick == 1) ? 5'h04 : 5'h0C;
            s = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 5))
                0: d = 32'h80;
                1: d = 32'h86;
                2: d = {19'd0, 1'($urandom), 2'd0, 1'($urandom), 1'($urandom), 8'd0};
                default: d = $urandom;
            endcase
            if (a == 5'h14 && d[0] && $urandom_range(0, 7) != 0) d[0] = 1'b0;
            if ($urandom_range(0, 9) == 0) begin
                rd_op(a, s, "R9");
            end else if ($urandom_range(0, 29) == 0) begin
                set_flag();
            end else begin
                wr_op(a, d, s, "R2");
            end
        end
        finish_run();
    end

endmodule